// File: doc/BRIEF.md
# Four-Channel Stepped-Rate PWM Generator

This block drives four independent pulse-width outputs. Software programs them through a byte-wide write/read register port. Each channel has four controls. The rate register holds a 2-bit range field and a 6-bit multiplier. The output rate is (multiplier + 1) times a base rate. The base is chosen from four values, each four times the one below it. An 8-bit duty code sets how many of the 256 slots in a period drive the active level. A polarity bit swaps the active level, and an enable bit starts or stops the channel.

Each channel keeps a phase accumulator that advances on a reference tick. The tick comes from a parameterised clock divider. On every tick the accumulator adds (multiplier + 1) << (2 × range). Each carry out of its FRAC_W-bit field moves an 8-bit slot counter on by one. Rate and duty writes go to holding registers. A running channel copies them into its working set only when its slot counter wraps, so no period is ever cut short. Polarity and enable act at once.

A stopped channel holds its output low, whatever its polarity. A running channel is always active for at least one slot per period.

Top module: `coarse_pwm4`

## Requirements
- R1: The rate register of channel c (c = 0..3) sits at address 0x08+c. Bits [7:6] are the range field s and bits [5:0] are the multiplier m. A running channel's slot counter advances once for every 2^FRAC_W / ((m+1)·4^s) reference ticks, and one output period is 256 slots.
- R2: The duty register of channel c sits at address 0x0C+c. With duty code N and polarity 0, a running channel drives 1 during slots 0..N of each period and 0 during the rest. A period therefore has (N+1)/256 active time, and code 0xFF gives a constant 1.
- R3: Bit 2+c of the register at address 0x05 inverts channel c's output while the channel runs. A change to this bit is visible in the cycle right after the write edge.
- R4: Bit 4+c of the register at address 0x07 enables channel c. Setting the bit starts the channel at slot 0 in the cycle after the write edge. A disabled channel outputs 0 whatever its polarity bit, and clearing the bit forces 0 in the next cycle.
- R5: A rate or duty write to a running channel changes nothing until the next slot-counter wrap. A write on an earlier edge is used from that wrap onward. A write on the wrap edge itself is first used one period later.
- R6: Reading addresses 0x05, 0x07 and 0x08..0x0F returns the whole byte last written there. Every other address reads 0x00, and a write to it changes no register.
- R7: A synchronous reset clears every register to 0x00, stops all channels and drives every output to 0.
- R8: The top code 0xFF (range 3, multiplier 63) advances one slot per reference tick. This gives the shortest period, 256 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Two functions can fall in the same clock edge: a duty write from the register port, and the period boundary at which a channel takes in its held settings. The bench lines this up by counting edges from the enable write. The duty write lands on edge 256, where the slot counter wraps from 255 to 0. The write is judged correct only if the following period still shows the old active count (16 cycles) and the period after it shows the new one (256 cycles). A second duty write, made in the middle of a period, must take effect at the very next wrap.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
   localparam int STEP_W = 2;
   localparam int MULT_W = 6;
   // (mult+1) needs MULT_W+1 bits, shifted by at most 2*(2^STEP_W-1)
   localparam int INC_W  = MULT_W + 1 + 2 * ((1 << STEP_W) - 1);

   localparam logic [7:0] ADR_POL  = 8'h05;
   localparam logic [7:0] ADR_EN   = 8'h07;
   localparam logic [7:0] ADR_RATE = 8'h08;
   localparam logic [7:0] ADR_DUTY = 8'h0C;
   localparam int POL_LSB = 2;
   localparam int EN_LSB  = 4;

   // accumulator increment for a rate register value
   function automatic logic [INC_W-1:0] rate_inc(input logic [7:0] rate);
      logic [INC_W-1:0] mult;
      mult = INC_W'(rate[MULT_W-1:0]) + INC_W'(1);
      return mult << {rate[7:6], 1'b0};
   endfunction
endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
module cpwm_regs
   import cpwm_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [7:0]             addr,
   input  logic [7:0]             wdata,
   output logic [7:0]             rdata,
   output logic [NUM_CH-1:0][7:0] rate_o,
   output logic [NUM_CH-1:0][7:0] duty_o,
   output logic [NUM_CH-1:0]      pol_o,
   output logic [NUM_CH-1:0]      en_o
);
   logic [7:0]             pol_r, en_r;
   logic [NUM_CH-1:0][7:0] rate_r, duty_r;
   logic [7:0]             rate_off, duty_off;

   assign rate_off = addr - ADR_RATE;
   assign duty_off = addr - ADR_DUTY;

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_r  <= '0;
         en_r   <= '0;
         rate_r <= '0;
         duty_r <= '0;
      end else if (wr_en) begin
         if (addr == ADR_POL) pol_r <= wdata;
         if (addr == ADR_EN)  en_r  <= wdata;
         for (int c = 0; c < NUM_CH; c++) begin
            if (rate_off == 8'(c)) rate_r[c] <= wdata;
            if (duty_off == 8'(c)) duty_r[c] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADR_POL) rdata = pol_r;
      if (addr == ADR_EN)  rdata = en_r;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rate_off == 8'(c)) rdata = rate_r[c];
         if (duty_off == 8'(c)) rdata = duty_r[c];
      end
   end

   assign rate_o = rate_r;
   assign duty_o = duty_r;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bits
      assign pol_o[c] = pol_r[POL_LSB + c];
      assign en_o[c]  = en_r[EN_LSB + c];
   end

   // R7: reset leaves control registers cleared
   a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> (en_o == '0 && pol_o == '0 && rdata == 8'h00 || addr != ADR_EN));
endmodule

// File: rtl/cpwm_chan.sv
`timescale 1ns/1ps
module cpwm_chan
   import cpwm_pkg::*;
#(
   parameter int FRAC_W = 12
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       en,
   input  logic       pol,
   input  logic [7:0] rate_reg,
   input  logic [7:0] duty_reg,
   output logic       pwm_o
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;
   logic [7:0]        slot_q, rate_act, duty_act;
   logic              carry, wrap;

   always_comb begin
      sum   = {1'b0, acc_q} + (FRAC_W + 1)'(rate_inc(rate_act));
      carry = tick & sum[FRAC_W];
      wrap  = carry & (slot_q == 8'hFF);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q    <= '0;
         slot_q   <= '0;
         rate_act <= '0;
         duty_act <= '0;
      end else if (!en) begin
         acc_q    <= '0;
         slot_q   <= '0;
         rate_act <= rate_reg;
         duty_act <= duty_reg;
      end else if (tick) begin
         acc_q <= sum[FRAC_W-1:0];
         if (carry) slot_q <= slot_q + 8'd1;
         if (wrap) begin
            rate_act <= rate_reg;
            duty_act <= duty_reg;
         end
      end
   end

   assign pwm_o = en & ((slot_q <= duty_act) ^ pol);

   // R5: working settings hold between boundaries
   a_r5_hold_settings: assert property (@(posedge clk) disable iff (rst)
      (en && !wrap) |=> ($stable(duty_act) && $stable(rate_act)));
   // R2: slot 0 is always active
   a_r2_slot0_active: assert property (@(posedge clk) disable iff (rst)
      (en && slot_q == 8'd0) |-> (pwm_o == !pol));
   // R1: at most one slot step per cycle
   a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
      (en && $past(en)) |-> (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 8'd1));
   // R4: a fresh enable starts at slot 0
   a_r4_start_slot0: assert property (@(posedge clk) disable iff (rst)
      $rose(en) |-> (slot_q == 8'd0));
endmodule

// File: rtl/coarse_pwm4.sv
`timescale 1ns/1ps
module coarse_pwm4
   import cpwm_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int FRAC_W   = 12,
   parameter int TICK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must be 1..4 to fit the register map");
   end
   if (FRAC_W + 1 < INC_W) begin : g_bad_frac
      $error("FRAC_W too small: more than one slot carry per tick");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   logic                   tick;
   logic [NUM_CH-1:0][7:0] rate_w, duty_w;
   logic [NUM_CH-1:0]      pol_w, en_w;

   if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (rst || div_q == DW'(TICK_DIV - 1)) div_q <= '0;
         else                                   div_q <= div_q + DW'(1);
      end
      assign tick = (div_q == DW'(TICK_DIV - 1));
   end

   cpwm_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .rate_o (rate_w),
      .duty_o (duty_w),
      .pol_o  (pol_w),
      .en_o   (en_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cpwm_chan #(.FRAC_W(FRAC_W)) u_chan (
         .clk      (clk),
         .rst      (rst),
         .tick     (tick),
         .en       (en_w[c]),
         .pol      (pol_w[c]),
         .rate_reg (rate_w[c]),
         .duty_reg (duty_w[c]),
         .pwm_o    (pwm_out[c])
      );
   end
endmodule

// File: tb/coarse_pwm4_test.sv
`timescale 1ns/1ps
module coarse_pwm4_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [3:0] pwm_out;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   logic [7:0] pol_sh = 8'h00;
   logic [7:0] en_sh  = 8'h00;

   always #2.5 clk = ~clk;

   coarse_pwm4 uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   typedef struct packed {
      logic [1:0]  ch;
      logic        pol;
      logic [7:0]  rate;
      logic [7:0]  duty;
      logic [15:0] high;
      logic [15:0] per;
   } vec_t;

   // high = active cycles per period, per = period in cycles (FRAC_W=12, one tick per clock)
   localparam vec_t VECS [0:7] = '{
      '{2'd0, 1'b0, 8'hFF, 8'h00, 16'd1,   16'd256},
      '{2'd1, 1'b0, 8'hFF, 8'h7F, 16'd128, 16'd256},
      '{2'd2, 1'b0, 8'hFF, 8'hFF, 16'd256, 16'd256},
      '{2'd3, 1'b0, 8'hBF, 8'h0F, 16'd64,  16'd1024},
      '{2'd0, 1'b1, 8'hDF, 8'h3F, 16'd384, 16'd512},
      '{2'd1, 1'b0, 8'h7F, 8'h01, 16'd32,  16'd4096},
      '{2'd2, 1'b1, 8'hFF, 8'hFF, 16'd0,   16'd256},
      '{2'd3, 1'b0, 8'h9F, 8'h03, 16'd32,  16'd2048}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // call at a negedge; the write lands on the next posedge; returns at the following negedge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #0.5;
      chk(tag, int'(rdata), int'(exp));
   endtask

   task automatic count_high(input int c, input int n, output int high);
      high = 0;
      for (int k = 0; k < n; k++) begin
         if (pwm_out[c]) high++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int hi;
      vec_t v;
      int c;

      // R7: reset state
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R7 outputs low after reset", int'(pwm_out), 0);
      rd(8'h05, 8'h00, "R7 polarity reg cleared");
      rd(8'h07, 8'h00, "R7 enable reg cleared");
      rd(8'h08, 8'h00, "R7 rate reg cleared");
      rd(8'h0F, 8'h00, "R7 duty reg cleared");

      // R6: readback and unmapped addresses
      @(negedge clk);
      wr(8'h05, 8'hA5);
      wr(8'h0D, 8'h3C);
      wr(8'h0A, 8'h81);
      wr(8'h06, 8'hFF);
      wr(8'h10, 8'h77);
      rd(8'h05, 8'hA5, "R6 polarity readback");
      rd(8'h0D, 8'h3C, "R6 duty readback");
      rd(8'h0A, 8'h81, "R6 rate readback");
      rd(8'h06, 8'h00, "R6 unmapped 0x06 reads zero");
      rd(8'h10, 8'h00, "R6 unmapped 0x10 reads zero");
      rd(8'h04, 8'h00, "R6 unmapped 0x04 reads zero");
      rd(8'h07, 8'h00, "R6 write to 0x06 left enable untouched");
      // R4: inverted but disabled channels stay low
      hi = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pwm_out != 4'b0000) hi++;
      end
      chk("R4 disabled inverted channels low", hi, 0);
      @(negedge clk);
      wr(8'h05, 8'h00);

      // R1/R2/R8: vector table
      for (int i = 0; i < 8; i++) begin
         v = VECS[i];
         c = int'(v.ch);
         @(negedge clk);
         pol_sh = 8'h00;
         pol_sh[c + 2] = v.pol;
         wr(8'h05, pol_sh);
         wr(8'h08 + 8'(c), v.rate);
         wr(8'h0C + 8'(c), v.duty);
         en_sh = 8'h00;
         en_sh[c + 4] = 1'b1;
         wr(8'h07, en_sh);
         count_high(c, int'(v.per), hi);
         chk($sformatf("R1/R2/R8 vec%0d active cycles per period", i), hi, int'(v.high));
         chk($sformatf("R1 vec%0d next period starts on schedule", i),
             int'(pwm_out[c]), int'(!v.pol));
         wr(8'h07, 8'h00);
         wr(8'h05, 8'h00);
         chk($sformatf("R4 vec%0d outputs low after disable", i), int'(pwm_out), 0);
      end

      // R5: mid-period duty write applies at the next wrap
      @(negedge clk);
      wr(8'h08, 8'hFF);
      wr(8'h0C, 8'h0F);
      wr(8'h07, 8'h10);
      repeat (99) @(negedge clk);
      wr(8'h0C, 8'hFF);
      count_high(0, 156, hi);
      chk("R5 mid-period write keeps old duty", hi, 0);
      count_high(0, 256, hi);
      chk("R5 new duty from next period", hi, 256);
      wr(8'h07, 8'h00);

      // R5: write on the wrap edge itself
      wr(8'h0C, 8'h0F);
      wr(8'h07, 8'h10);
      repeat (255) @(negedge clk);
      wr(8'h0C, 8'hFF);
      count_high(0, 256, hi);
      chk("R5 boundary-edge write waits one period", hi, 16);
      count_high(0, 256, hi);
      chk("R5 boundary-edge write then applied", hi, 256);
      wr(8'h07, 8'h00);

      // R3: polarity acts at once; R4: disable acts at once
      wr(8'h09, 8'hFF);
      wr(8'h0D, 8'h7F);
      wr(8'h07, 8'h20);
      repeat (9) @(negedge clk);
      chk("R3 output active before invert", int'(pwm_out[1]), 1);
      wr(8'h05, 8'h08);
      chk("R3 invert visible next cycle", int'(pwm_out[1]), 0);
      wr(8'h07, 8'h00);
      chk("R4 disable forces low next cycle", int'(pwm_out), 0);
      wr(8'h05, 8'h00);

      // R7: reset while running
      wr(8'h0A, 8'hFF);
      wr(8'h0E, 8'hFF);
      wr(8'h07, 8'h40);
      chk("R7 channel running before reset", int'(pwm_out[2]), 1);
      rst = 1'b1;
      @(negedge clk);
      chk("R7 reset forces outputs low", int'(pwm_out), 0);
      rst = 1'b0;
      rd(8'h07, 8'h00, "R7 enable cleared by reset");
      rd(8'h0A, 8'h00, "R7 rate cleared by reset");
      rd(8'h0E, 8'h00, "R7 duty cleared by reset");

      finish_run();
   end
endmodule